// File: doc/BRIEF.md
# Bridge Type-1 Configuration Register Block

This block keeps the bridge-specific part of a type-1 configuration header: bus numbers, secondary latency timer, the I/O, memory and prefetchable window base/limit registers with their upper extensions, bridge control, and a small subsystem-ID capability. It also returns the fixed identity fields, which are status, secondary status, header type and class code. Software reaches it through a dword-addressed port with four byte enables. Reads are combinational on the dword index. Each write lands in the following clock edge, and only in bytes whose enable is set and in bits that the register's write mask allows.

Two events leave the block, each a single clock wide, in the cycle after the write. The first is a remap strobe. It tells a downstream window decoder to reload its base/limit values, and it fires only when the written bytes touch routing state. The second is a secondary-bus reset pulse, which fires when software raises the reset bit in bridge control. A separate input empties every forwarding window in one cycle. Another pair of inputs decides whether the secondary latency timer can be written.

Top module: `cfgbr_bridge_cfg`

## Requirements
- R1: After reset, every writable bit reads zero: bus numbers (byte 0x18..0x1A), latency timer (0x1B), window registers (0x1C..0x1D, 0x20..0x33) and bridge control (0x3E..0x3F). The read-only window type nibbles keep their values: I/O type 1 in bits 3:0 of bytes 0x1C/0x1D, and prefetchable type 1 in bits 3:0 of bytes 0x24/0x26.
- R2: A write changes a byte only when its enable bit (bit b for byte b of the dword) is set, and only in bits that are writable. Those bits are: all of 0x18..0x1A; bits 7:4 of the I/O base/limit bytes; bits 15:4 of the memory and prefetchable base/limit words; all of 0x28..0x33; and bits 11:0 of bridge control.
- R3: Status (0x06) reads 0x0230 and secondary status (0x1E) reads 0x0220. Class (0x09..0x0B) reads 0x060400. Header type (0x0E) reads 0x01, with bit 7 taken from the multifunction input.
- R4: A cycle with `fwd_off` high sets every writable base bit to one, clears every writable limit bit, zeroes 0x28..0x2F, and raises the remap strobe. The I/O upper registers are left as they are.
- R5: The remap strobe is high in the cycle after a write whose enabled bytes overlap 0x04..0x05, 0x1C..0x1D, 0x20..0x33 or 0x3E..0x3F.
- R6: A write whose enabled bytes touch none of those ranges, or that has no byte enables, leaves the remap strobe low.
- R7: The secondary reset pulse (bridge control bit 6, dword 0x3C bit 22) is high in the cycle after a write takes that bit from 0 to 1. Rewriting a 1 or clearing it gives no pulse.
- R8: While `sec_express` is high and `slt_override` is low, byte 0x1B reads zero and ignores writes. Otherwise it is a plain read/write byte.
- R9: The capability pointer (0x34) reads the capability offset (0x40). The capability reads ID 0x0D in its first byte, subsystem vendor ID 0xA5C3 at offset 4 and subsystem ID 0x3C5A at offset 6. These are fixed, and writes do not change them.
- R10: Dwords that hold no implemented field read zero.
- R11: When `fwd_off` and a window write fall in the same cycle, the emptied values win in the window registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write request for this cycle |
| cfg_dw | input | ADDR_W | Dword index for the read and the write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_dw` (combinational) |
| fwd_off | input | 1 | Empty all forwarding windows |
| sec_express | input | 1 | Secondary side is a serial express link |
| slt_override | input | 1 | Keep the latency timer writable regardless |
| multi_func | input | 1 | Multifunction bit reported in the header type |
| remap_pulse | output | 1 | One-cycle window reload strobe |
| sbr_pulse | output | 1 | One-cycle secondary-bus reset pulse |

## Verification
The assertions assume that `sec_express`, `slt_override` and `multi_func` are quasi-static, changing only between accesses. They also assume that `fwd_off` is a single-cycle command. The stimulus changes those inputs only on idle read cycles and pulses `fwd_off` for one cycle at a time. It also drives `fwd_off` together with a window write once, so that the priority rule is exercised. Write data deliberately sets read-only and masked bits, and a reference model stored per byte predicts every read and both strobes.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;

  localparam int NSLOT   = 8;
  localparam int DW_CMD  = 1;
  localparam int DW_CLS  = 2;
  localparam int DW_HDR  = 3;
  localparam int DW_BUS  = 6;
  localparam int DW_IOBL = 7;
  localparam int DW_MEM  = 8;
  localparam int DW_PREF = 9;
  localparam int DW_PBU  = 10;
  localparam int DW_PLU  = 11;
  localparam int DW_IOU  = 12;
  localparam int DW_CAPP = 13;
  localparam int DW_CTL  = 15;
  localparam int SBR_BIT = 22;

  typedef logic [NSLOT-1:0][31:0] slots_t;

  function automatic logic [31:0] be_expand(logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] merge_write(logic [31:0] old, logic [31:0] wd,
                                              logic [3:0] be, logic [31:0] wmask);
    logic [31:0] sel;
    sel = be_expand(be) & wmask;
    return (old & ~sel) | (wd & sel);
  endfunction

  // true when the enabled bytes of a write touch routing state
  function automatic logic routing_hit(logic [31:0] dwx, logic [3:0] be);
    logic hit;
    case (dwx)
      32'(DW_CMD), 32'(DW_IOBL):                       hit = |be[1:0];
      32'(DW_MEM), 32'(DW_PREF), 32'(DW_PBU),
      32'(DW_PLU), 32'(DW_IOU):                        hit = |be;
      32'(DW_CTL):                                     hit = |be[3:2];
      default:                                         hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/cfgbr_remap_detect.sv
module cfgbr_remap_detect
  import cfgbr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] dw,
  input  logic [3:0]        be,
  input  logic              fwd_off,
  output logic              remap_pulse
);

  logic remap_ev;
  assign remap_ev = (wr && routing_hit(32'(dw), be)) || fwd_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remap_pulse <= 1'b0;
    else        remap_pulse <= remap_ev;
  end

  // R5
  remap_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |-> $past(wr || fwd_off));

  // R6
  remap_no_empty_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && be == 4'h0 && !fwd_off) |=> !remap_pulse);

endmodule

// File: rtl/cfgbr_regs.sv
module cfgbr_regs
  import cfgbr_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter bit          IO_32     = 1'b1,
  parameter bit          PREF_64   = 1'b1,
  parameter logic [15:0] CTL_WMASK = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] dw,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  input  logic              fwd_off,
  input  logic              slt_wen,
  output slots_t            slots,
  output logic              sbr_pulse
);

  logic [31:0] dwx;
  assign dwx = 32'(dw);

  function automatic int slot_dw(int s);
    case (s)
      0: return DW_BUS;
      1: return DW_IOBL;
      2: return DW_MEM;
      3: return DW_PREF;
      4: return DW_PBU;
      5: return DW_PLU;
      6: return DW_IOU;
      default: return DW_CTL;
    endcase
  endfunction

  function automatic logic [31:0] slot_wmask(int s, logic slt_on);
    case (s)
      0: return slt_on ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
      1: return 32'h0000_F0F0;
      2, 3: return 32'hFFF0_FFF0;
      4, 5: return PREF_64 ? 32'hFFFF_FFFF : 32'h0;
      6: return IO_32 ? 32'hFFFF_FFFF : 32'h0;
      default: return {CTL_WMASK, 16'h0};
    endcase
  endfunction

  // base fields all ones, limit fields zero, upper halves cleared
  function automatic logic [31:0] empty_value(int s);
    case (s)
      1: return 32'h0000_00F0;
      2, 3: return 32'h0000_FFF0;
      default: return 32'h0;
    endcase
  endfunction

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam bit EMPTIED = (s >= 1) && (s <= 5);
    logic [31:0] q, nv;
    always_comb begin
      nv = q;
      if (wr && dwx == 32'(slot_dw(s)))
        nv = merge_write(q, wdata, be, slot_wmask(s, slt_wen));
      if (EMPTIED && fwd_off)
        nv = empty_value(s);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nv;
    end
    assign slots[s] = q;
  end

  logic ctl_cur, ctl_nxt, sbr_ev;
  assign ctl_cur = slots[NSLOT-1][SBR_BIT];
  assign ctl_nxt = (wr && dwx == 32'(DW_CTL) && be[SBR_BIT/8] && CTL_WMASK[SBR_BIT-16])
                   ? wdata[SBR_BIT] : ctl_cur;
  assign sbr_ev  = !ctl_cur && ctl_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sbr_pulse <= 1'b0;
    else        sbr_pulse <= sbr_ev;
  end

  // R7
  sbr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sbr_pulse |-> (slots[NSLOT-1][SBR_BIT] && !$past(slots[NSLOT-1][SBR_BIT])));

  // R4
  fwd_empties_windows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_off |=> ((slots[2][15:4] > slots[2][31:20]) &&
                 (slots[1][7:4] > slots[1][15:12]) &&
                 (slots[3][15:4] > slots[3][31:20])));

  // R6
  empty_be_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && be == 4'h0 && !fwd_off) |=> $stable(slots));

endmodule

// File: rtl/cfgbr_rdmux.sv
module cfgbr_rdmux
  import cfgbr_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter bit          IO_32   = 1'b1,
  parameter bit          PREF_64 = 1'b1,
  parameter int          CAP_OFF = 64,
  parameter logic [15:0] SVID    = 16'hA5C3,
  parameter logic [15:0] SSID    = 16'h3C5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dw,
  input  slots_t            slots,
  input  logic              slt_wen,
  input  logic              multi_func,
  output logic [31:0]       rdata
);

  localparam int          CAP_DW = CAP_OFF / 4;
  localparam logic [3:0]  IO_T   = IO_32 ? 4'h1 : 4'h0;
  localparam logic [31:0] PREF_T = PREF_64 ? 32'h0001_0001 : 32'h0;
  localparam logic [15:0] STAT   = 16'h0230;
  localparam logic [15:0] SSTAT  = 16'h0220;

  logic [31:0] dwx;
  assign dwx = 32'(dw);

  always_comb begin
    rdata = '0;
    case (dwx)
      32'(DW_CMD):  rdata = {STAT, 16'h0};
      32'(DW_CLS):  rdata = {24'h06_04_00, 8'h00};
      32'(DW_HDR):  rdata = {8'h00, multi_func, 7'h01, 16'h0};
      32'(DW_BUS):  rdata = slots[0] & (slt_wen ? 32'hFFFF_FFFF : 32'h00FF_FFFF);
      32'(DW_IOBL): rdata = slots[1] | {SSTAT, 4'h0, IO_T, 4'h0, IO_T};
      32'(DW_MEM):  rdata = slots[2];
      32'(DW_PREF): rdata = slots[3] | PREF_T;
      32'(DW_PBU):  rdata = slots[4];
      32'(DW_PLU):  rdata = slots[5];
      32'(DW_IOU):  rdata = slots[6];
      32'(DW_CAPP): rdata = {24'h0, 8'(CAP_OFF)};
      32'(DW_CTL):  rdata = slots[7];
      default:      rdata = '0;
    endcase
    if (dwx == 32'(CAP_DW))     rdata = 32'h0000_000D;
    if (dwx == 32'(CAP_DW + 1)) rdata = {SSID, SVID};
  end

  // R8
  slt_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwx == 32'(DW_BUS) && !slt_wen) |-> rdata[31:24] == 8'h00);

endmodule

// File: rtl/cfgbr_bridge_cfg.sv
module cfgbr_bridge_cfg
  import cfgbr_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter bit          IO_32     = 1'b1,
  parameter bit          PREF_64   = 1'b1,
  parameter int          CAP_OFF   = 64,
  parameter logic [15:0] SVID      = 16'hA5C3,
  parameter logic [15:0] SSID      = 16'h3C5A,
  parameter logic [15:0] CTL_WMASK = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_dw,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              fwd_off,
  input  logic              sec_express,
  input  logic              slt_override,
  input  logic              multi_func,
  output logic              remap_pulse,
  output logic              sbr_pulse
);

  slots_t slots;
  logic   slt_wen;
  assign slt_wen = !sec_express || slt_override;

  cfgbr_regs #(
    .ADDR_W(ADDR_W), .IO_32(IO_32), .PREF_64(PREF_64), .CTL_WMASK(CTL_WMASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .dw(cfg_dw), .be(cfg_be),
    .wdata(cfg_wdata), .fwd_off(fwd_off), .slt_wen(slt_wen),
    .slots(slots), .sbr_pulse(sbr_pulse)
  );

  cfgbr_remap_detect #(.ADDR_W(ADDR_W)) u_remap (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .dw(cfg_dw), .be(cfg_be),
    .fwd_off(fwd_off), .remap_pulse(remap_pulse)
  );

  cfgbr_rdmux #(
    .ADDR_W(ADDR_W), .IO_32(IO_32), .PREF_64(PREF_64),
    .CAP_OFF(CAP_OFF), .SVID(SVID), .SSID(SSID)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .dw(cfg_dw), .slots(slots), .slt_wen(slt_wen),
    .multi_func(multi_func), .rdata(cfg_rdata)
  );

  // R3
  hdr_type_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == ADDR_W'(DW_HDR)) |-> (cfg_rdata[22:16] == 7'h01 && cfg_rdata[23] == multi_func));

endmodule

// File: tb/tb_cfgbr_bridge_cfg.sv
`timescale 1ns/1ps
module tb_cfgbr_bridge_cfg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fwd_off = 1'b0, sec_express = 1'b0, slt_override = 1'b0, multi_func = 1'b0;
  logic        remap_pulse, sbr_pulse;

  always #4 clk = ~clk;

  cfgbr_bridge_cfg dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fwd_off(fwd_off),
    .sec_express(sec_express), .slt_override(slt_override), .multi_func(multi_func),
    .remap_pulse(remap_pulse), .sbr_pulse(sbr_pulse)
  );

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  logic [7:0] st [0:255];
  logic q_exp = 0, q_ovr = 0, q_mf = 0;
  logic exp_remap = 0, exp_sbr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic slt_en();
    return !q_exp || q_ovr;
  endfunction

  function automatic logic [7:0] wmk(int o);
    if (o >= 24 && o <= 26) return 8'hFF;
    if (o == 27) return slt_en() ? 8'hFF : 8'h00;
    if (o == 28 || o == 29) return 8'hF0;
    if (o == 32 || o == 34 || o == 36 || o == 38) return 8'hF0;
    if (o == 33 || o == 35 || o == 37 || o == 39) return 8'hFF;
    if (o >= 40 && o <= 51) return 8'hFF;
    if (o == 62) return 8'hFF;
    if (o == 63) return 8'h0F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] rov(int o);
    case (o)
      6: return 8'h30;  7: return 8'h02;  10: return 8'h04; 11: return 8'h06;
      14: return {q_mf, 7'h01};
      28, 29, 36, 38: return 8'h01;
      30: return 8'h20; 31: return 8'h02;
      52: return 8'h40; 64: return 8'h0D;
      68: return 8'hC3; 69: return 8'hA5; 70: return 8'h5A; 71: return 8'h3C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] mread(int dw);
    logic [31:0] v;
    for (int b = 0; b < 4; b++) v[8*b +: 8] = (st[dw*4+b] & wmk(dw*4+b)) | rov(dw*4+b);
    return v;
  endfunction

  function automatic bit routes(int o);
    return o == 4 || o == 5 || o == 28 || o == 29 || (o >= 32 && o <= 51) || o == 62 || o == 63;
  endfunction

  function automatic string rtag(int dw);
    if (dw == 1 || dw == 2 || dw == 3) return "R3";
    if ((dw >= 6 && dw <= 12) || dw == 15) return "R2";
    if (dw == 13 || dw == 16 || dw == 17) return "R9";
    return "R10";
  endfunction

  task automatic mclear();
    for (int i = 0; i < 256; i++) st[i] = 8'h00;
  endtask

  task automatic step(input logic w, input int dw, input logic [3:0] be,
                      input logic [31:0] d, input logic f, input string tag);
    logic old6;
    bit   hit;
    @(negedge clk);
    chk(remap_pulse === exp_remap, exp_remap ? "R5" : "R6", 32'(remap_pulse), 32'(exp_remap));
    chk(sbr_pulse === exp_sbr, "R7", 32'(sbr_pulse), 32'(exp_sbr));
    cfg_wr = w; cfg_dw = 6'(dw); cfg_be = be; cfg_wdata = d; fwd_off = f;
    sec_express = q_exp; slt_override = q_ovr; multi_func = q_mf;
    #1;
    chk(cfg_rdata === mread(dw), (tag != "") ? tag : rtag(dw), cfg_rdata, mread(dw));
    old6 = st[62][6];
    hit = 0;
    if (w) begin
      for (int b = 0; b < 4; b++) if (be[b]) begin
        int o = dw*4 + b;
        logic [7:0] m = wmk(o);
        st[o] = (st[o] & ~m) | (d[8*b +: 8] & m);
        if (routes(o)) hit = 1;
      end
    end
    if (f) begin
      st[28] = 8'hF0; st[29] = 8'h00;
      st[32] = 8'hF0; st[33] = 8'hFF; st[34] = 8'h00; st[35] = 8'h00;
      st[36] = 8'hF0; st[37] = 8'hFF; st[38] = 8'h00; st[39] = 8'h00;
      for (int i = 40; i < 48; i++) st[i] = 8'h00;
    end
    exp_remap = hit || f;
    exp_sbr   = w && !old6 && st[62][6];
  endtask

  task automatic rd(input int dw, input string tag);
    step(0, dw, 4'h0, 32'h0, 0, tag);
  endtask

  task automatic wrt(input int dw, input logic [3:0] be, input logic [31:0] d, input string tag);
    step(1, dw, be, d, 0, tag);
    rd(dw, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr = 0; fwd_off = 0;
    mclear(); exp_remap = 0; exp_sbr = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mclear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R3 R9 R10: reset state sweep
    for (int i = 0; i < 20; i++) rd(i, (i >= 6 && i <= 15) ? "R1" : "");
    // R2: bus numbers and latency timer, no routing hit
    wrt(6, 4'hF, 32'h40_12_05_01, "R2");
    wrt(6, 4'h2, 32'hFFFF_FFFF, "R2");
    // R2 R5: windows with partial enables; type and low nibbles read-only
    wrt(7, 4'h3, 32'hFFFF_FFFF, "R2");
    wrt(8, 4'h5, 32'hABCD_1234, "R2");
    wrt(9, 4'hF, 32'hFFFF_FFFF, "R2");
    wrt(10, 4'h8, 32'h8000_0000, "R2");
    wrt(12, 4'hF, 32'h1234_5678, "R2");
    // R5 R6: command word hits, status byte does not
    wrt(1, 4'h1, 32'hFFFF_FFFF, "R3");
    wrt(1, 4'h8, 32'hFFFF_FFFF, "R3");
    // R6: interrupt-line half of dword 0x3C does not route
    wrt(15, 4'h3, 32'hFFFF_FFFF, "R2");
    // R9: capability is fixed
    wrt(16, 4'hF, 32'hFFFF_FFFF, "R9");
    wrt(17, 4'hF, 32'h0, "R9");
    wrt(13, 4'hF, 32'h0, "R9");
    // R7: reset bit edges
    wrt(15, 4'h4, 32'h0040_0000, "R7");
    wrt(15, 4'h4, 32'h0040_0000, "R7");
    wrt(15, 4'h4, 32'h0000_0000, "R7");
    wrt(15, 4'hC, 32'hFFFF_0000, "R7");
    // R6: empty enables change nothing
    wrt(8, 4'h0, 32'hFFFF_FFFF, "R6");
    // R8: express secondary hides latency timer
    q_exp = 1; rd(6, "R8");
    wrt(6, 4'h8, 32'h7700_0000, "R8");
    q_ovr = 1; rd(6, "R8");
    wrt(6, 4'h8, 32'h5500_0000, "R8");
    q_ovr = 0; rd(6, "R8");
    q_exp = 0; rd(6, "R8");
    // R3: multifunction bit
    q_mf = 1; rd(3, "R3"); rd(3, "R3");
    q_mf = 0; rd(3, "R3");
    // R4: empty the windows
    step(0, 8, 4'h0, 32'h0, 1, "R4");
    for (int i = 7; i <= 12; i++) rd(i, "R4");
    // R11: fwd with a simultaneous window write
    wrt(8, 4'hF, 32'h5550_1110, "R2");
    step(1, 8, 4'hF, 32'h1234_5670, 1, "R11");
    rd(8, "R11"); rd(7, "R11");
    // R1: reset after traffic
    do_reset();
    for (int i = 6; i <= 15; i++) rd(i, "R1");
    rd(20, "R10"); rd(63, "R10");
    @(negedge clk);
    chk(remap_pulse === exp_remap, "R6", 32'(remap_pulse), 32'(exp_remap));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule